// File: doc/BRIEF.md
# Coded Word-Stream Frame Extraction Reader

This block sits between a received-frame byte stream and a host processor that pulls frames out one 32-bit word per register read. Incoming bytes are packed into words in a small buffer. The host sees a single read-data port. Frame boundaries, the byte count of the final word, truncation and aborts are signalled inside that same word stream as reserved 32-bit code values. Any payload word that happens to equal a reserved value is preceded by an escape code, so the host can always tell code from data.

Any header in front of the frame, and the four check-sequence bytes at its tail, are ordinary payload bytes to this block. They leave in arrival order and are never interpreted. A data-present output tells the host that at least one terminated frame is still waiting, so an interrupt routine can keep draining until it drops. A synchronous flush discards everything held and returns the block to idle.

Top module: `xtr_reader`

## Requirements
- R1: After reset, rd_data shows the not-ready code 0x07000080, data_present is low and in_ready is high.
- R2: Accepted bytes are packed four to a word, the first byte of a word in bits 7:0. Each rd_strobe sampled at a clock edge advances the stream by exactly one word. rd_data always shows the word that the next strobe consumes.
- R3: A reserved code has bits 7:0 equal to 0x80, bits 23:8 and 31:27 zero, and a selector in bits 26:24. When a frame ends normally with k bytes (1 to 4) in its last word, the stream carries the status code with selector 4-k, and the last word follows on the next read. Unused upper bytes of the last word are zero.
- R4: A frame ended with in_prune set yields status 0x04000080, which carries 4 valid bytes. The last word follows with its missing upper bytes filled with zero.
- R5: Any payload word equal to one of the eight reserved codes is sent as the escape code 0x06000080 followed by the literal word. This also applies to the last word after a status code.
- R6: A read while no word is waiting returns 0x07000080 and changes nothing.
- R7: A byte marked in_abort ends the frame. The stream carries 0x05000080 followed by one filler word 0x00000000. Bytes of an incomplete word in that frame are dropped.
- R8: data_present is high exactly while at least one terminated frame (normal, pruned or aborted) has not had its final word or filler read.
- R9: in_ready is low while the word buffer is full. Bytes offered then are not taken.
- R10: A cycle with flush high empties the buffer, drops any partial word and any half-delivered escape or status sequence. On the next cycle the reader is idle: not-ready code, data_present low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of all held data |
| in_valid | input | 1 | Byte offered on in_data |
| in_ready | output | 1 | Byte is taken when in_valid and in_ready are both high |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte starts a new frame (word lane restarts at 0) |
| in_eof | input | 1 | Byte is the last of its frame |
| in_prune | input | 1 | With in_eof, the frame was truncated |
| in_abort | input | 1 | Frame aborted; in_data is ignored |
| rd_strobe | input | 1 | Host read; consumes the word on rd_data |
| rd_data | output | 32 | Current stream word or code |
| data_present | output | 1 | At least one terminated frame awaits draining |

## Verification
The word that terminates one frame can enter the buffer in the same cycle that the host reads the final word of an older frame. The frame counter behind data_present then sees an increment and a decrement together. The bench provokes this by streaming frames back to back while strobing every cycle, and at other read rates. A behavioural model built from queues predicts each rd_data word and the data_present level, and compares them on every clock. Flush is also applied while escape and status sequences are half read, and the model expects idle on the very next cycle.

// File: rtl/xtr_pkg.sv
package xtr_pkg;

   localparam int WORD_BYTES = 4;
   localparam int WORD_W     = 8 * WORD_BYTES;

   localparam logic [2:0] SEL_PRUNE = 3'd4;
   localparam logic [2:0] SEL_ABORT = 3'd5;
   localparam logic [2:0] SEL_ESC   = 3'd6;
   localparam logic [2:0] SEL_IDLE  = 3'd7;

   typedef enum logic [1:0] {
      TK_DATA  = 2'd0,
      TK_LAST  = 2'd1,
      TK_ABORT = 2'd2
   } tok_kind_e;

   typedef struct packed {
      tok_kind_e         kind;
      logic [2:0]        sel;
      logic [WORD_W-1:0] word;
   } tok_t;

   function automatic logic [WORD_W-1:0] mk_code(input logic [2:0] s);
      return {5'b0, s, 16'h0000, 8'h80};
   endfunction

   function automatic logic is_reserved(input logic [WORD_W-1:0] w);
      return (w[31:27] == 5'b0) && (w[23:0] == 24'h000080);
   endfunction

endpackage

// File: rtl/xtr_packer.sv
module xtr_packer
   import xtr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush,
   input  logic       in_valid,
   input  logic       in_ready,
   input  logic [7:0] in_data,
   input  logic       in_sof,
   input  logic       in_eof,
   input  logic       in_prune,
   input  logic       in_abort,
   output logic       push,
   output tok_t       push_tok
);

   logic [WORD_W-1:0] acc;
   logic [1:0]        lane;
   logic [1:0]        start_lane;
   logic [WORD_W-1:0] merged;
   logic              take;

   assign take       = in_valid && in_ready && !flush;
   assign start_lane = in_sof ? 2'd0 : lane;

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      assign merged[8*g +: 8] = (start_lane == 2'(g)) ? in_data :
                                (2'(g) < start_lane)  ? acc[8*g +: 8] : 8'h00;
   end

   always_comb begin
      push          = 1'b0;
      push_tok      = '0;
      push_tok.kind = TK_DATA;
      if (take) begin
         if (in_abort) begin
            push          = 1'b1;
            push_tok.kind = TK_ABORT;
            push_tok.sel  = SEL_ABORT;
         end else if (in_eof) begin
            push          = 1'b1;
            push_tok.kind = TK_LAST;
            push_tok.sel  = in_prune ? SEL_PRUNE : {1'b0, 2'd3 - start_lane};
            push_tok.word = merged;
         end else if (start_lane == 2'd3) begin
            push          = 1'b1;
            push_tok.word = merged;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         lane <= '0;
      end else if (flush) begin
         acc  <= '0;
         lane <= '0;
      end else if (take) begin
         if (push) begin
            acc  <= '0;
            lane <= '0;
         end else begin
            acc  <= merged;
            lane <= start_lane + 2'd1;
         end
      end
   end

endmodule

// File: rtl/xtr_fifo.sv
module xtr_fifo
   import xtr_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic push,
   input  tok_t din,
   input  logic pop,
   output tok_t head,
   output logic head_valid,
   output logic full
);

   localparam int AW = $clog2(DEPTH);

   initial begin : chk_depth
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $error("xtr_fifo: DEPTH must be a power of two, at least 2");
   end

   tok_t          mem [DEPTH];
   logic [AW:0]   wp;
   logic [AW:0]   rp;

   assign head_valid = (wp != rp);
   assign full       = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign head       = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wp[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (flush) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
      end
   end

   AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n)
                        !(push && full && !flush)); // R9
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                        !(pop && !head_valid)); // R6

endmodule

// File: rtl/xtr_encoder.sv
module xtr_encoder
   import xtr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  tok_t              head,
   input  logic              head_valid,
   input  logic              rd_strobe,
   output logic              pop,
   output logic [WORD_W-1:0] rd_data
);

   typedef enum logic [2:0] {
      PH_IDLE, PH_LIT, PH_LASTW, PH_LASTLIT, PH_FILL
   } phase_e;

   phase_e phase, phase_nxt;
   logic   pop_cand;

   always_comb begin
      phase_nxt = phase;
      pop_cand  = 1'b0;
      rd_data   = mk_code(SEL_IDLE);
      unique case (phase)
         PH_IDLE: begin
            if (head_valid) begin
               unique case (head.kind)
                  TK_LAST: begin
                     rd_data   = mk_code(head.sel);
                     phase_nxt = PH_LASTW;
                  end
                  TK_ABORT: begin
                     rd_data   = mk_code(SEL_ABORT);
                     phase_nxt = PH_FILL;
                  end
                  default: begin
                     if (is_reserved(head.word)) begin
                        rd_data   = mk_code(SEL_ESC);
                        phase_nxt = PH_LIT;
                     end else begin
                        rd_data  = head.word;
                        pop_cand = 1'b1;
                     end
                  end
               endcase
            end
         end
         PH_LASTW: begin
            if (is_reserved(head.word)) begin
               rd_data   = mk_code(SEL_ESC);
               phase_nxt = PH_LASTLIT;
            end else begin
               rd_data   = head.word;
               pop_cand  = 1'b1;
               phase_nxt = PH_IDLE;
            end
         end
         PH_LIT, PH_LASTLIT: begin
            rd_data   = head.word;
            pop_cand  = 1'b1;
            phase_nxt = PH_IDLE;
         end
         PH_FILL: begin
            rd_data   = '0;
            pop_cand  = 1'b1;
            phase_nxt = PH_IDLE;
         end
         default: phase_nxt = PH_IDLE;
      endcase
   end

   assign pop = rd_strobe && pop_cand && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         phase <= PH_IDLE;
      else if (flush)     phase <= PH_IDLE;
      else if (rd_strobe) phase <= phase_nxt;
   end

   AST_PHASE_HAS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
                          (phase != PH_IDLE) |-> head_valid); // R3
   AST_ESC_THEN_LIT:   assert property (@(posedge clk) disable iff (!rst_n)
                          (rd_strobe && !flush && rd_data == mk_code(SEL_ESC))
                          |=> is_reserved(rd_data)); // R5

endmodule

// File: rtl/xtr_reader.sv
module xtr_reader
   import xtr_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        flush,
   input  logic        in_valid,
   output logic        in_ready,
   input  logic [7:0]  in_data,
   input  logic        in_sof,
   input  logic        in_eof,
   input  logic        in_prune,
   input  logic        in_abort,
   input  logic        rd_strobe,
   output logic [31:0] rd_data,
   output logic        data_present
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   logic          push;
   tok_t          push_tok;
   logic          pop;
   tok_t          head;
   logic          head_valid;
   logic          full;
   logic [CNT_W-1:0] frames;
   logic          frm_in;
   logic          frm_out;

   assign in_ready = !full;

   xtr_packer u_packer (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .in_sof   (in_sof),
      .in_eof   (in_eof),
      .in_prune (in_prune),
      .in_abort (in_abort),
      .push     (push),
      .push_tok (push_tok)
   );

   xtr_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .push       (push),
      .din        (push_tok),
      .pop        (pop),
      .head       (head),
      .head_valid (head_valid),
      .full       (full)
   );

   xtr_encoder u_enc (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .head       (head),
      .head_valid (head_valid),
      .rd_strobe  (rd_strobe),
      .pop        (pop),
      .rd_data    (rd_data)
   );

   assign frm_in  = push && (push_tok.kind != TK_DATA);
   assign frm_out = pop  && (head.kind != TK_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                frames <= '0;
      else if (flush)            frames <= '0;
      else if (frm_in && !frm_out) frames <= frames + 1'b1;
      else if (frm_out && !frm_in) frames <= frames - 1'b1;
   end

   assign data_present = (frames != '0);

   AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                      flush |=> (!data_present && rd_data == mk_code(SEL_IDLE))); // R10
   AST_DP_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
                      (data_present && !rd_strobe && !flush) |=> data_present); // R8

endmodule

// File: tb/xtr_reader_bench.sv
module xtr_reader_bench;

   localparam logic [31:0] C_NR  = 32'h0700_0080;
   localparam logic [31:0] C_ESC = 32'h0600_0080;
   localparam logic [31:0] C_AB  = 32'h0500_0080;
   localparam logic [31:0] C_PR  = 32'h0400_0080;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [7:0] in_data = '0;
   logic in_sof = 1'b0, in_eof = 1'b0, in_prune = 1'b0, in_abort = 1'b0;
   logic rd_strobe = 1'b0;
   logic [31:0] rd_data;
   logic data_present;

   always #10 clk = ~clk;

   xtr_reader u_xtr_reader (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_sof(in_sof), .in_eof(in_eof), .in_prune(in_prune), .in_abort(in_abort),
      .rd_strobe(rd_strobe), .rd_data(rd_data), .data_present(data_present)
   );

   int checks = 0;
   int failures = 0;
   int rd_mode = 0;
   int cyc = 0;
   bit model_on = 0;
   bit done_flag = 0;

   logic [31:0] exp_q[$];
   bit          endq[$];
   logic [7:0]  cur[$];
   int          pending = 0;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h time=%0t", tag, got, exp, $time);
      end
   endtask

   function automatic bit resv(input logic [31:0] w);
      return (w[31:27] == 0) && (w[23:0] == 24'h80);
   endfunction

   function automatic string tag_of(input logic [31:0] w, input bit after_esc);
      if (after_esc)            return "R5";
      if (w == C_NR)            return "R6";
      if (w == C_ESC)           return "R5";
      if (w == C_AB)            return "R7";
      if (w == C_PR)            return "R4";
      if (resv(w))              return "R3";
      return "R2";
   endfunction

   function automatic void put_word(input logic [31:0] w, input bit fin);
      if (resv(w)) begin
         exp_q.push_back(C_ESC); endq.push_back(0);
      end
      exp_q.push_back(w); endq.push_back(fin);
   endfunction

   function automatic logic [31:0] cur_word();
      logic [31:0] w = '0;
      for (int i = 0; i < cur.size(); i++) w[8*i +: 8] = cur[i];
      return w;
   endfunction

   // behavioural model of the input side
   always @(posedge clk) begin
      if (rst_n && model_on) begin
         if (flush) begin
            exp_q.delete(); endq.delete(); cur.delete(); pending = 0;
         end else if (in_valid && in_ready) begin
            if (in_sof) cur.delete();
            if (in_abort) begin
               cur.delete();
               exp_q.push_back(C_AB); endq.push_back(0);
               exp_q.push_back(32'h0); endq.push_back(1);
               pending++;
            end else begin
               cur.push_back(in_data);
               if (in_eof) begin
                  if (in_prune) begin
                     exp_q.push_back(C_PR); endq.push_back(0);
                  end else begin
                     exp_q.push_back(32'h80 | (32'(4 - cur.size()) << 24)); endq.push_back(0);
                  end
                  put_word(cur_word(), 1);
                  cur.delete();
                  pending++;
               end else if (cur.size() == 4) begin
                  put_word(cur_word(), 0);
                  cur.delete();
               end
            end
         end
      end
   end

   // per-cycle output comparison and read driver
   bit last_was_esc = 0;
   always @(negedge clk) begin
      cyc++;
      if (rst_n && model_on) begin
         logic [31:0] e;
         bit go;
         e = (exp_q.size() != 0) ? exp_q[0] : C_NR;
         check(tag_of(e, last_was_esc && exp_q.size() != 0), rd_data, e);
         check("R8", {31'b0, data_present}, {31'b0, pending > 0});
         go = (rd_mode == 1) || (rd_mode == 2 && (cyc % 3 == 0));
         rd_strobe = go;
         if (go && exp_q.size() != 0) begin
            last_was_esc = (exp_q[0] == C_ESC);
            if (endq[0]) pending--;
            void'(exp_q.pop_front()); void'(endq.pop_front());
         end
      end else begin
         rd_strobe = 0;
      end
   end

   task automatic put_byte(input logic [7:0] d, input bit s, input bit e,
                           input bit p, input bit a);
      @(negedge clk);
      in_valid = 1; in_data = d; in_sof = s; in_eof = e; in_prune = p; in_abort = a;
      while (!in_ready) @(negedge clk);
   endtask

   task automatic idle_in();
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0; in_prune = 0; in_abort = 0;
   endtask

   task automatic send_frame(input int n, input int seed, input bit prn);
      for (int i = 0; i < n; i++)
         put_byte(8'(seed * 7 + i * 13 + 1), i == 0, i == n - 1, prn && (i == n - 1), 0);
      idle_in();
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait_cyc(3);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1", rd_data, C_NR);
      check("R1", {31'b0, data_present}, 32'h0);
      check("R1", {31'b0, in_ready}, 32'h1);
      model_on = 1;

      // R2 R3 normal frames, continuous reads
      rd_mode = 1;
      send_frame(10, 1, 0);
      send_frame(8, 2, 0);
      send_frame(5, 3, 0);
      send_frame(1, 4, 0);
      wait_cyc(10);

      // R5 colliding payload, including last word after status
      put_byte(8'h80, 1, 0, 0, 0); put_byte(8'h00, 0, 0, 0, 0);
      put_byte(8'h00, 0, 0, 0, 0); put_byte(8'h06, 0, 0, 0, 0);
      put_byte(8'h11, 0, 0, 0, 0); put_byte(8'h22, 0, 0, 0, 0);
      put_byte(8'h33, 0, 0, 0, 0); put_byte(8'h44, 0, 0, 0, 0);
      put_byte(8'h80, 0, 0, 0, 0); put_byte(8'h00, 0, 0, 0, 0);
      put_byte(8'h00, 0, 0, 0, 0); put_byte(8'h03, 0, 1, 0, 0);
      idle_in();
      wait_cyc(10);

      // R4 pruned, R7 abort, slow reads
      rd_mode = 2;
      send_frame(6, 5, 1);
      for (int i = 0; i < 5; i++) put_byte(8'(i + 40), i == 0, 0, 0, 0);
      put_byte(8'hFF, 0, 0, 0, 1);
      put_byte(8'hEE, 0, 0, 0, 1);
      idle_in();
      send_frame(7, 6, 0);
      wait_cyc(40);

      // R8 frames queued with reads off
      rd_mode = 0;
      send_frame(4, 7, 0);
      send_frame(3, 8, 0);
      wait_cyc(5);
      check("R8", {31'b0, data_present}, 32'h1);
      rd_mode = 1;
      wait_cyc(15);

      // R9 fill the buffer
      rd_mode = 0;
      done_flag = 0;
      fork
         begin send_frame(48, 9, 0); done_flag = 1; end
      join_none
      wait_cyc(45);
      check("R9", {31'b0, in_ready}, 32'h0);
      rd_mode = 1;
      wait (done_flag);
      wait_cyc(30);

      // R10 flush mid-frame and mid escape sequence
      rd_mode = 0;
      for (int i = 0; i < 6; i++) put_byte(8'(i + 3), i == 0, 0, 0, 0);
      idle_in();
      send_frame(4, 10, 0);
      @(negedge clk); flush = 1;
      @(negedge clk); flush = 0;
      check("R10", rd_data, C_NR);
      check("R10", {31'b0, data_present}, 32'h0);
      rd_mode = 1;
      send_frame(9, 11, 0);
      wait_cyc(10);
      put_byte(8'h80, 1, 0, 0, 0); put_byte(8'h00, 0, 0, 0, 0);
      put_byte(8'h00, 0, 0, 0, 0); put_byte(8'h07, 0, 1, 0, 0);
      idle_in();
      rd_mode = 0;
      wait_cyc(3);
      rd_mode = 1;
      @(negedge clk); rd_mode = 0;
      @(negedge clk); flush = 1;
      @(negedge clk); flush = 0;
      check("R10", rd_data, C_NR);
      rd_mode = 1;

      // R8 back-to-back frames, terminator write meets final read
      for (int f = 0; f < 6; f++) send_frame(4 + f, 20 + f, f == 3);
      rd_mode = 2;
      for (int f = 0; f < 4; f++) send_frame(2 + f, 30 + f, 0);
      rd_mode = 1;
      wait_cyc(60);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule